// File: doc/BRIEF.md
# Programmable-Tap Input Delay Line

This block is the registered input stage in front of one multiplier operand. A twelve-bit two's-complement sample is pushed into a sixteen-deep shift stack on every clock where the port enable is high. On each push, every older entry moves one stage deeper. A four-bit tap word is captured on every clock, whether or not a push happens. That captured word picks the stage whose contents load the output register on the next edge.

The operand can therefore be delayed by one to sixteen pushes. The delay counts enabled pushes, not clocks. A stalled source freezes the stack, but the tap can still be changed while it is frozen. Four copies of this stage feed a dual-product accumulator: one for each multiplier input.

A synchronous reset clears the stack, the tap register and the output to zero, so the design starts from a known state.

Top module: `tap_delay_line`

## Requirements
- R1: While reset is high at a clock edge, the stack, the tap register and the output register are all cleared to zero. After reset is released, with enable held low, the output stays zero for every tap value 0 to 15.
- R2: On a clock edge with enable high, the sample at `sampleIn` enters stage 0 and each stage n takes the old value of stage n-1. With continuous pushes and a steady tap value s, the output after the edge that pushes value v equals v-1-s.
- R3: On a clock edge with enable low, no stage of the stack changes.
- R4: Tap value 0 selects stage 0. With pushes on consecutive edges, a sample pushed at edge k is on the output after edge k+1.
- R5: Tap value 15 selects stage 15. With pushes on consecutive edges, a sample pushed at edge k is on the output after edge k+16.
- R6: The tap word is registered. The value on `tapSel` at edge t picks the stage loaded into the output at edge t+1.
- R7: While enable is low, changing the tap word still changes the output. After the change is registered, the next edge loads the newly selected stage of the frozen stack.
- R8: Samples pass through bit-exact as twelve-bit two's-complement words, including the extremes 12'h800 and 12'h7FF and the value 12'hFFF.
- R9: A push and a tap change may occur on the same edge. The output loaded at the following edge reads the newly selected stage of the stack, and that stack already includes the push.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| pushEn | input | 1 | Port enable; high pushes `sampleIn` into the stack |
| tapSel | input | 4 | Tap word; 0 gives a delay of 1 push, 15 gives 16 pushes |
| sampleIn | input | 12 | Two's-complement input sample |
| sampleOut | output | 12 | Registered delayed sample |

## Verification
The stack shift and the tap re-selection can land on the same edge. When they do, the output register reads a stage whose index and contents both changed one edge earlier. The bench provokes this with long runs in which enable and tap are drawn at random each cycle, interleaved with deliberate stretches of stalls and retaps. Each output is judged against a queue model that advances only on pushes and latches the tap one cycle late. The bench also sweeps every tap under continuous pushes and checks the closed-form value v-1-s.

// File: rtl/tap_delay_pkg.sv
package tap_delay_pkg;
  // Widest tap index the control strobe can carry; depth must not exceed 2**TAP_FIELD_W.
  localparam int unsigned TAP_FIELD_W = 8;

  // Strobes passed from the control half to the datapath half.
  typedef struct packed {
    logic                   push;   // shift the stack on this edge
    logic [TAP_FIELD_W-1:0] tap;    // registered stage index for the output mux
  } tapCtrl_t;
endpackage

// File: rtl/tap_delay_ctrl.sv
module tap_delay_ctrl
  import tap_delay_pkg::*;
#(
  parameter int unsigned DEPTH = 16,
  localparam int unsigned SELW = $clog2(DEPTH)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            pushEn,
  input  logic [SELW-1:0] tapSel,
  output tapCtrl_t        ctrl
);

  logic [SELW-1:0] tapQ;

  // Tap word is captured every clock, independent of the push enable.
  always_ff @(posedge clk) begin
    if (rst) tapQ <= '0;
    else     tapQ <= tapSel;
  end

  always_comb begin
    ctrl.push = pushEn & ~rst;
    ctrl.tap  = TAP_FIELD_W'(tapQ);
  end

  // R1: tap register comes out of reset at zero
  assert_tap_reset_R1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (ctrl.tap == '0));

  // R6: tap seen by the datapath is the word presented one clock earlier
  assert_tap_latched_R6: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (ctrl.tap == TAP_FIELD_W'($past(tapSel))));

endmodule

// File: rtl/tap_delay_dp.sv
module tap_delay_dp
  import tap_delay_pkg::*;
#(
  parameter int unsigned WIDTH = 12,
  parameter int unsigned DEPTH = 16,
  localparam int unsigned SELW = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst,
  input  tapCtrl_t         ctrl,
  input  logic [WIDTH-1:0] sampleIn,
  output logic [WIDTH-1:0] sampleOut
);

  logic [WIDTH-1:0] stageQ [DEPTH];
  logic [WIDTH-1:0] tapped;
  logic [WIDTH-1:0] outQ;

  // Shift stack: stage 0 takes the new sample, each deeper stage takes its neighbour.
  for (genvar g = 0; g < DEPTH; g++) begin : gStage
    if (g == 0) begin : gTop
      always_ff @(posedge clk) begin
        if (rst)            stageQ[g] <= '0;
        else if (ctrl.push) stageQ[g] <= sampleIn;
      end
    end else begin : gDeep
      always_ff @(posedge clk) begin
        if (rst)            stageQ[g] <= '0;
        else if (ctrl.push) stageQ[g] <= stageQ[g-1];
      end
    end
  end

  // Output mux driven by the registered tap, then a final output register.
  always_comb tapped = stageQ[ctrl.tap[SELW-1:0]];

  always_ff @(posedge clk) begin
    if (rst) outQ <= '0;
    else     outQ <= tapped;
  end

  assign sampleOut = outQ;

  // R3: a clock without a push leaves both ends of the stack untouched
  assert_hold_R3: assert property (@(posedge clk) disable iff (rst)
    !ctrl.push |=> (stageQ[0] == $past(stageQ[0])) &&
                   (stageQ[DEPTH-1] == $past(stageQ[DEPTH-1])));

  // R2: a push moves stage 0 into stage 1
  assert_shift_R2: assert property (@(posedge clk) disable iff (rst)
    ctrl.push |=> (stageQ[1] == $past(stageQ[0])));

  // R4: tap 0 loads the top stage into the output
  assert_min_tap_R4: assert property (@(posedge clk) disable iff (rst)
    (ctrl.tap == '0) |=> (sampleOut == $past(stageQ[0])));

  // R5: the deepest tap loads the bottom stage into the output
  assert_max_tap_R5: assert property (@(posedge clk) disable iff (rst)
    (ctrl.tap == TAP_FIELD_W'(DEPTH-1)) |=> (sampleOut == $past(stageQ[DEPTH-1])));

endmodule

// File: rtl/tap_delay_line.sv
module tap_delay_line
  import tap_delay_pkg::*;
#(
  parameter int unsigned WIDTH = 12,
  parameter int unsigned DEPTH = 16
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     pushEn,
  input  logic [$clog2(DEPTH)-1:0] tapSel,
  input  logic [WIDTH-1:0]         sampleIn,
  output logic [WIDTH-1:0]         sampleOut
);

  tapCtrl_t ctrl;

  tap_delay_ctrl #(.DEPTH(DEPTH)) uCtrl (
    .clk    (clk),
    .rst    (rst),
    .pushEn (pushEn),
    .tapSel (tapSel),
    .ctrl   (ctrl)
  );

  tap_delay_dp #(.WIDTH(WIDTH), .DEPTH(DEPTH)) uDp (
    .clk       (clk),
    .rst       (rst),
    .ctrl      (ctrl),
    .sampleIn  (sampleIn),
    .sampleOut (sampleOut)
  );

endmodule

// File: tb/tap_delay_line_test.sv
module tap_delay_line_test;
  localparam int CLK_PERIOD = 10;
  localparam int W = 12;
  localparam int D = 16;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         pushEn = 1'b0;
  logic [3:0]   tapSel = '0;
  logic [W-1:0] sampleIn = '0;
  logic [W-1:0] sampleOut;

  int checks = 0;
  int fails  = 0;

  // Reference queue: advances only on pushes; the tap is latched one cycle late.
  logic [W-1:0] mStage [D];
  int           mTap = 0;

  tap_delay_line #(.WIDTH(W), .DEPTH(D)) uut (
    .clk(clk), .rst(rst), .pushEn(pushEn), .tapSel(tapSel),
    .sampleIn(sampleIn), .sampleOut(sampleOut)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: sampleOut=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // One clock: drive inputs, take the edge, advance the model, check at the negedge.
  task automatic cyc(input logic e, input logic [W-1:0] d, input logic [3:0] s,
                     input string tag);
    logic [W-1:0] exp;
    pushEn = e; sampleIn = d; tapSel = s;
    @(posedge clk);
    exp = mStage[mTap];
    if (e) begin
      for (int i = D-1; i > 0; i--) mStage[i] = mStage[i-1];
      mStage[0] = d;
    end
    mTap = s;
    @(negedge clk);
    chk(tag, sampleOut, exp);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    checks++; fails++;
    $display("FAIL watchdog: run did not complete, actual=hung expected=done");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    for (int i = 0; i < D; i++) mStage[i] = '0;

    // R1: reset with junk on the inputs clears everything
    pushEn = 1'b1; sampleIn = 12'hABC; tapSel = 4'd7;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1", sampleOut, '0);
    rst = 1'b0;
    mTap = 0;
    for (int s = 0; s < D; s++) cyc(1'b0, 12'h555, 4'(s), "R1");

    // R2, R4, R5: every tap under continuous pushes, model plus closed form v-1-s
    for (int s = 0; s < D; s++) begin
      for (int i = 0; i < 40; i++) begin
        logic [W-1:0] v;
        string tag;
        v = W'(s * 100 + i);
        tag = (s == 0) ? "R4" : (s == D-1) ? "R5" : "R2";
        cyc(1'b1, v, 4'(s), tag);
        if (i >= 18) chk(tag, sampleOut, W'(s * 100 + i - 1 - s));
      end
    end

    // R3 and R7: freeze the stack, sweep taps, contents must stay readable and unchanged
    for (int i = 0; i < D; i++) cyc(1'b1, W'(12'h300 + i * 7), 4'd0, "R2");
    for (int s = 0; s < D; s++) cyc(1'b0, 12'hF0F, 4'(s), "R7");
    for (int s = D-1; s >= 0; s--) cyc(1'b0, 12'h0F0, 4'(s), "R3");

    // R8: extremes pass bit-exact through tap 0
    cyc(1'b1, 12'h800, 4'd0, "R8");
    cyc(1'b1, 12'h7FF, 4'd0, "R8");
    cyc(1'b1, 12'hFFF, 4'd0, "R8");
    cyc(1'b1, 12'h001, 4'd0, "R8");
    cyc(1'b0, 12'h000, 4'd0, "R8");
    chk("R8", sampleOut, 12'h001);
    cyc(1'b0, 12'h000, 4'd2, "R8");
    cyc(1'b0, 12'h000, 4'd2, "R8");
    chk("R8", sampleOut, 12'h7FF);

    // R6: alternate the tap every clock while frozen
    for (int i = 0; i < 20; i++) cyc(1'b0, 12'h123, (i % 2 == 0) ? 4'd3 : 4'd9, "R6");

    // R9: push and retap drawn at random, often on the same edge
    for (int i = 0; i < 3000; i++) begin
      logic e;
      e = ($urandom_range(0, 3) != 0);
      cyc(e, W'($urandom), 4'($urandom), "R9");
    end

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule